// File: doc/BRIEF.md
# Gyro SPI Command Framer

This block talks to a digital angular-rate sensor over a four-wire serial bus. A host presents one request at a time: fetch the rate sample, read a 16-bit register pair, or write a 16-bit register pair. The block builds a 32-bit command word, completes it with an odd-parity bit and shifts it out most significant bit first. It then decodes the 32-bit word that the sensor shifts back.

The sensor answers a read or a rate request one frame late. For those requests the block runs a second frame after a short gap with chip select high, and decodes the word captured in that second frame. A write uses a single frame and then holds the bus idle for a programmable recovery time. The data, status and error fields are returned on one done strobe. A write to the offset-correction register is range-checked before any frame starts. A readback of that register is sign-extended.

Top module: `gyro_spi_framer`

## Requirements
- R1: After reset, cs_n is 1, sclk, mosi, busy, done and reject are 0, and rdata, status and err_bits are 0.
- R2: The command word carries an opcode in bits 31:24 (rate sample 0x20 for op=0, register read 0x80 for op=1, register write 0x40 for op=2) and the 7-bit register address in bits 23:17. A write also carries its 16-bit value in bits 16:1. Every other bit is 0 except bit 0.
- R3: Bit 0 of every command word is set exactly when this is needed to make the number of ones in the 32-bit word odd.
- R4: Each frame holds cs_n low for exactly 32 sclk pulses. sclk idles low, mosi changes only while sclk is low and the input is sampled on the rising sclk edge, most significant bit first. In the second frame of a read or rate request, mosi stays 0.
- R5: A read or rate request runs two frames separated by GAP_CYCLES+1 cycles with cs_n high. done follows the accepting clock edge by 128*HALF_DIV+GAP_CYCLES+2 cycles.
- R6: For a rate request, rdata is bits 25:10 of the second frame's reply word. For a register read, it is bits 20:5 of that word.
- R7: status takes reply bits 27:26 and err_bits takes reply bits 31:29. These come from the second frame for reads and rate requests, and from the single frame for writes.
- R8: A write runs one frame, keeps busy high for WRITE_HOLD_CYCLES more cycles, and raises done 64*HALF_DIV+WRITE_HOLD_CYCLES+1 cycles after the accepting edge, with rdata 0.
- R9: A write to OFFSET_ADDR whose value, taken as signed 16-bit, lies outside -1024..1023 (wdata[15:10] not all equal) starts no frame. done and reject then rise in the cycle after the accepting edge, with rdata, status and err_bits 0.
- R10: A register read of OFFSET_ADDR returns reply bits 14:5 sign-extended to 16 bits.
- R11: A request with op=3 is rejected in the same way as in R9.
- R12: busy is high from the cycle after acceptance until done. done is a one-cycle pulse seen with busy low, and requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | 0 rate sample, 1 register read, 2 register write, 3 reserved |
| addr | input | 7 | Even register address of the pair |
| wdata | input | 16 | Value for a register write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Decoded data field |
| status | output | 2 | Decoded status field |
| err_bits | output | 3 | Decoded error field |
| reject | output | 1 | Last request was refused without bus traffic |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to sensor |
| miso | input | 1 | Serial data from sensor |

## Verification
Counting the clock edge that samples req as cycle 0, done is due at cycle 0 for a refused request. It is due at cycle 64*HALF_DIV+WRITE_HOLD_CYCLES+1 for a write, and at cycle 128*HALF_DIV+GAP_CYCLES+2 for a read or rate request. cs_n is expected low over cycles 0 to 64*HALF_DIV-1, and again from 64*HALF_DIV+GAP_CYCLES+1 to 128*HALF_DIV+GAP_CYCLES for two-frame requests. The bench model counts cycles from acceptance and compares busy, done and cs_n every cycle against these windows. It compares the decoded fields and the words captured by a behavioural sensor only in the cycle where done is due.

// File: rtl/gyro_pkg.sv
package gyro_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 16;
    localparam int ADDR_LSB = 17;

    localparam logic [7:0] OPC_RATE  = 8'h20;
    localparam logic [7:0] OPC_WRITE = 8'h40;
    localparam logic [7:0] OPC_READ  = 8'h80;

    typedef enum logic [1:0] {
        OP_RATE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } gyro_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [1:0]        status;
        logic [2:0]        err;
    } gyro_result_t;
endpackage

// File: rtl/gyro_cmd_build.sv
module gyro_cmd_build
    import gyro_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OFFSET_ADDR = 7'h12,
    parameter int                CORR_W      = 11
) (
    input  gyro_op_e              op,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [WORD_W-1:0]     word,
    output logic                  allowed
);
    localparam int SIGN_LSB = CORR_W - 1;

    logic [WORD_W-1:0] body;
    logic              in_range;

    always_comb begin
        body = '0;
        case (op)
            OP_RATE:  body[WORD_W-1 -: 8] = OPC_RATE;
            OP_READ:  body[WORD_W-1 -: 8] = OPC_READ;
            OP_WRITE: begin
                body[WORD_W-1 -: 8] = OPC_WRITE;
                body[DATA_W:1]      = wdata;
            end
            default:  body = '0;
        endcase
        if (op != OP_RATE) begin
            body[ADDR_LSB +: ADDR_W] = addr;
        end
        word    = body;
        word[0] = ~^body[WORD_W-1:1];
    end

    always_comb begin
        in_range = (&wdata[DATA_W-1:SIGN_LSB]) | ~(|wdata[DATA_W-1:SIGN_LSB]);
        allowed  = (op != OP_RSVD) &&
                   !((op == OP_WRITE) && (addr == OFFSET_ADDR) && !in_range);
    end
endmodule

// File: rtl/gyro_reply_decode.sv
module gyro_reply_decode
    import gyro_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OFFSET_ADDR = 7'h12,
    parameter int                READBACK_W  = 10
) (
    input  logic [WORD_W-1:0] rx,
    input  gyro_op_e          op,
    input  logic [ADDR_W-1:0] addr,
    output gyro_result_t      res
);
    localparam int RD_LSB   = 5;
    localparam int RATE_LSB = 10;
    localparam int EXT_W    = DATA_W - READBACK_W;

    always_comb begin
        res.status = rx[27:26];
        res.err    = rx[31:29];
        case (op)
            OP_RATE: res.data = rx[RATE_LSB +: DATA_W];
            OP_READ: begin
                if (addr == OFFSET_ADDR) begin
                    res.data = {{EXT_W{rx[RD_LSB+READBACK_W-1]}},
                                rx[RD_LSB +: READBACK_W]};
                end else begin
                    res.data = rx[RD_LSB +: DATA_W];
                end
            end
            default: res.data = '0;
        endcase
    end
endmodule

// File: rtl/gyro_spi_engine.sv
module gyro_spi_engine
    import gyro_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    output logic              frame_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic [DIV_W-1:0]  div;
        logic [BIT_W-1:0]  bitn;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic              fdone;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d       = eng_q;
        eng_d.fdone = 1'b0;
        if (!eng_q.active) begin
            if (start) begin
                eng_d.active = 1'b1;
                eng_d.tx     = tx_word;
                eng_d.div    = '0;
                eng_d.bitn   = '0;
                eng_d.sclk   = 1'b0;
            end
        end else if (eng_q.div == DIV_LAST) begin
            eng_d.div = '0;
            if (!eng_q.sclk) begin
                eng_d.sclk = 1'b1;
                eng_d.rx   = {eng_q.rx[WORD_W-2:0], miso};
            end else begin
                eng_d.sclk = 1'b0;
                if (eng_q.bitn == BIT_LAST) begin
                    eng_d.active = 1'b0;
                    eng_d.fdone  = 1'b1;
                end else begin
                    eng_d.bitn = eng_q.bitn + 1'b1;
                    eng_d.tx   = {eng_q.tx[WORD_W-2:0], 1'b0};
                end
            end
        end else begin
            eng_d.div = eng_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sclk       = eng_q.sclk;
    assign cs_n       = ~eng_q.active;
    assign mosi       = eng_q.active & eng_q.tx[WORD_W-1];
    assign frame_done = eng_q.fdone;
    assign rx_word    = eng_q.rx;
endmodule

// File: rtl/gyro_spi_framer.sv
module gyro_spi_framer
    import gyro_pkg::*;
#(
    parameter int                HALF_DIV          = 2,
    parameter int                GAP_CYCLES        = 4,
    parameter int                WRITE_HOLD_CYCLES = 10,
    parameter logic [6:0]        OFFSET_ADDR       = 7'h12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [1:0]  op,
    input  logic [6:0]  addr,
    input  logic [15:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic [1:0]  status,
    output logic [2:0]  err_bits,
    output logic        reject,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int MAX_WAIT = (GAP_CYCLES > WRITE_HOLD_CYCLES) ? GAP_CYCLES : WRITE_HOLD_CYCLES;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(WRITE_HOLD_CYCLES - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_FRAME1, ST_GAP, ST_FRAME2, ST_HOLD
    } seq_e;

    typedef struct packed {
        seq_e              st;
        gyro_op_e          op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        gyro_result_t      pend;
        gyro_result_t      res;
        logic              rej;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    gyro_op_e          op_in;
    logic [WORD_W-1:0] cmd_word;
    logic              cmd_ok;
    logic [WORD_W-1:0] eng_tx;
    logic              eng_start;
    logic              eng_fdone;
    logic [WORD_W-1:0] eng_rx;
    gyro_result_t      dec_res;

    assign op_in = gyro_op_e'(op);

    gyro_cmd_build #(
        .OFFSET_ADDR (OFFSET_ADDR)
    ) u_build (
        .op      (op_in),
        .addr    (addr),
        .wdata   (wdata),
        .word    (cmd_word),
        .allowed (cmd_ok)
    );

    gyro_reply_decode #(
        .OFFSET_ADDR (OFFSET_ADDR)
    ) u_decode (
        .rx   (eng_rx),
        .op   (seq_q.op),
        .addr (seq_q.addr),
        .res  (dec_res)
    );

    assign eng_tx = (seq_q.st == ST_IDLE) ? cmd_word : '0;

    gyro_spi_engine #(
        .HALF_DIV (HALF_DIV)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .tx_word    (eng_tx),
        .miso       (miso),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .frame_done (eng_fdone),
        .rx_word    (eng_rx)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        eng_start  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req) begin
                    if (cmd_ok) begin
                        eng_start  = 1'b1;
                        seq_d.st   = ST_FRAME1;
                        seq_d.op   = op_in;
                        seq_d.addr = addr;
                    end else begin
                        seq_d.done = 1'b1;
                        seq_d.rej  = 1'b1;
                        seq_d.res  = '0;
                    end
                end
            end
            ST_FRAME1: begin
                if (eng_fdone) begin
                    seq_d.cnt = '0;
                    if (seq_q.op == OP_WRITE) begin
                        seq_d.st   = ST_HOLD;
                        seq_d.pend = dec_res;
                    end else begin
                        seq_d.st = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (seq_q.cnt == GAP_LAST) begin
                    eng_start = 1'b1;
                    seq_d.st  = ST_FRAME2;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_FRAME2: begin
                if (eng_fdone) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.res  = dec_res;
                    seq_d.rej  = 1'b0;
                    seq_d.done = 1'b1;
                end
            end
            ST_HOLD: begin
                if (seq_q.cnt == HOLD_LAST) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.res  = seq_q.pend;
                    seq_d.rej  = 1'b0;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, op: OP_RATE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st != ST_IDLE);
    assign done     = seq_q.done;
    assign rdata    = seq_q.res.data;
    assign status   = seq_q.res.status;
    assign err_bits = seq_q.res.err;
    assign reject   = seq_q.rej;
endmodule

// File: rtl/gyro_spi_framer_chk.sv
module gyro_spi_framer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        reject,
    input logic [15:0] rdata,
    input logic        sclk,
    input logic        cs_n
);
    AST_SCLK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n); // R4
    AST_FRAME_ENDS_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sclk); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reject) |=> !done); // R12
    AST_NO_FRAME_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R12
    AST_DATA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done); // R6
    AST_REJECT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reject) |-> (cs_n && $past(!busy))); // R9
endmodule

bind gyro_spi_framer gyro_spi_framer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .reject (reject),
    .rdata  (rdata),
    .sclk   (sclk),
    .cs_n   (cs_n)
);

// File: tb/tb_gyro_spi_framer.sv
module tb_gyro_spi_framer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int GAP        = 4;
    localparam int WRH        = 10;
    localparam logic [6:0] OFS = 7'h12;
    localparam int L_RD = 128*HALF_DIV + GAP + 2;
    localparam int L_WR = 64*HALF_DIV + WRH + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [6:0]  addr = 7'd0;
    logic [15:0] wdata = 16'd0;
    logic        busy, done, reject, sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic [15:0] rdata;
    logic [1:0]  status;
    logic [2:0]  err_bits;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gyro_spi_framer #(
        .HALF_DIV (HALF_DIV), .GAP_CYCLES (GAP),
        .WRITE_HOLD_CYCLES (WRH), .OFFSET_ADDR (OFS)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req (req), .op (op), .addr (addr),
        .wdata (wdata), .busy (busy), .done (done), .rdata (rdata),
        .status (status), .err_bits (err_bits), .reject (reject),
        .sclk (sclk), .cs_n (cs_n), .mosi (mosi), .miso (miso)
    );

    // behavioural sensor
    logic [31:0] rsp_q[$];
    logic [31:0] cap_q[$];
    int          cnt_q[$];
    logic [31:0] sens_sh;
    logic [31:0] mosi_sh;
    int          sclk_cnt;

    always @(negedge cs_n) begin
        sens_sh  = (rsp_q.size() > 0) ? rsp_q.pop_front() : 32'h0;
        miso     = sens_sh[31];
        mosi_sh  = 32'h0;
        sclk_cnt = 0;
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            sens_sh = sens_sh << 1;
            miso    = sens_sh[31];
        end
    end
    always @(posedge sclk) begin
        if (!cs_n) begin
            mosi_sh  = {mosi_sh[30:0], mosi};
            sclk_cnt = sclk_cnt + 1;
        end
    end
    always @(posedge cs_n) begin
        cap_q.push_back(mosi_sh);
        cnt_q.push_back(sclk_cnt);
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cmd(input logic [1:0] o, input logic [6:0] a,
                                            input logic [15:0] d);
        logic [31:0] w;
        case (o)
            2'd0: w = 32'h2000_0000;
            2'd1: w = 32'h8000_0000 | (32'(a) << 17);
            default: w = 32'h4000_0000 | (32'(a) << 17) | (32'(d) << 1);
        endcase
        if ($countones(w) % 2 == 0) w[0] = 1'b1;
        return w;
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [6:0] a, input logic [15:0] d,
                          input logic [31:0] r1, input logic [31:0] r2, input bit inject);
        bit          rej, two;
        int          lat;
        logic [31:0] rep;
        logic [15:0] exp_data;
        string       dtag;
        rej = (o == 2'd3) || (o == 2'd2 && a == OFS && !((&d[15:10]) || !(|d[15:10])));
        two = !rej && (o != 2'd2);
        lat = rej ? 0 : (o == 2'd2 ? L_WR : L_RD);
        rsp_q.delete(); rsp_q.push_back(r1); rsp_q.push_back(r2);
        cap_q.delete(); cnt_q.delete();
        @(negedge clk);
        req = 1'b1; op = o; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k <= lat; k++) begin
            bit exp_cs;
            if (k > 0) @(negedge clk);
            if (inject && k == 5) begin req = 1'b1; op = 2'd2; addr = 7'h08; end
            if (inject && k == 6) req = 1'b0;
            if (rej) exp_cs = 1'b1;
            else if (k <= 64*HALF_DIV - 1) exp_cs = 1'b0;
            else if (two && k >= 64*HALF_DIV + GAP + 1 && k <= 128*HALF_DIV + GAP) exp_cs = 1'b0;
            else exp_cs = 1'b1;
            check(busy == (k < lat), "R12 busy window", busy, (k < lat));
            check(done == (k == lat), two ? "R5 done timing" : (rej ? "R9 done timing" : "R8 done timing"),
                  done, (k == lat));
            check(cs_n == exp_cs, rej ? "R9 cs_n" : "R5 cs_n", cs_n, exp_cs);
        end
        rep = two ? r2 : r1;
        if (rej) begin
            exp_data = 16'h0; dtag = (o == 2'd3) ? "R11 rdata" : "R9 rdata";
        end else if (o == 2'd0) begin
            exp_data = rep[25:10]; dtag = "R6 rate data";
        end else if (o == 2'd1 && a == OFS) begin
            exp_data = {{6{rep[14]}}, rep[14:5]}; dtag = "R10 offset readback";
        end else if (o == 2'd1) begin
            exp_data = rep[20:5]; dtag = "R6 read data";
        end else begin
            exp_data = 16'h0; dtag = "R8 write rdata";
        end
        check(rdata == exp_data, dtag, rdata, exp_data);
        check(status == (rej ? 2'd0 : rep[27:26]), "R7 status", status, rej ? 2'd0 : rep[27:26]);
        check(err_bits == (rej ? 3'd0 : rep[31:29]), "R7 err_bits", err_bits, rej ? 3'd0 : rep[31:29]);
        check(reject == rej, (o == 2'd3) ? "R11 reject" : "R9 reject", reject, rej);
        check(cap_q.size() == (rej ? 0 : (two ? 2 : 1)), "R9 frame count", cap_q.size(),
              rej ? 0 : (two ? 2 : 1));
        if (!rej && cap_q.size() >= 1) begin
            check(cap_q[0] == exp_cmd(o, a, d), "R2 command word", cap_q[0], exp_cmd(o, a, d));
            check($countones(cap_q[0]) % 2 == 1, "R3 odd parity", $countones(cap_q[0]), 1);
            check(cnt_q[0] == 32, "R4 sclk pulses", cnt_q[0], 32);
        end
        if (two && cap_q.size() >= 2) begin
            check(cap_q[1] == 32'h0, "R4 idle mosi in reply frame", cap_q[1], 0);
            check(cnt_q[1] == 32, "R4 sclk pulses frame 2", cnt_q[1], 32);
        end
        @(negedge clk);
        check(busy == 1'b0, "R12 request while busy ignored", busy, 0);
        check(done == 1'b0, "R12 done single pulse", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 bus lines in reset",
              {cs_n, sclk, mosi}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && reject == 1'b0, "R1 flags after reset",
              {busy, done, reject}, 0);
        check(rdata == 16'h0 && status == 2'd0 && err_bits == 3'd0, "R1 results after reset",
              {rdata, status, err_bits}, 0);
        // rate sample: first reply must be ignored
        run_op(2'd0, 7'h00, 16'h0000, 32'hFFFF_FFFF, 32'h8AB3_C401, 1'b0);
        // negative rate value
        run_op(2'd0, 7'h00, 16'h0000, 32'h0000_0000, 32'h27FF_FC00, 1'b0);
        // plain register read, plus a request injected while busy
        run_op(2'd1, 7'h0A, 16'h0000, 32'h1234_5678, 32'hA41B_EEF0, 1'b1);
        run_op(2'd1, 7'h04, 16'h0000, 32'h0000_0000, 32'h0001_FFE0, 1'b0);
        // offset register readback, negative and positive
        run_op(2'd1, OFS, 16'h0000, 32'h0, 32'h0000_7E40, 1'b0);
        run_op(2'd1, OFS, 16'h0000, 32'h0, 32'h0000_3E40, 1'b0);
        // plain write
        run_op(2'd2, 7'h08, 16'hBEEF, 32'hE400_0000, 32'h0, 1'b0);
        // offset writes at the limits and beyond
        run_op(2'd2, OFS, 16'h03FF, 32'h2C00_0000, 32'h0, 1'b0);
        run_op(2'd2, OFS, 16'hFC00, 32'h0, 32'h0, 1'b0);
        run_op(2'd2, OFS, 16'h0400, 32'h0, 32'h0, 1'b0);
        run_op(2'd2, OFS, 16'hFBFF, 32'h0, 32'h0, 1'b0);
        // reserved op
        run_op(2'd3, 7'h02, 16'h0000, 32'h0, 32'h0, 1'b0);
        // normal request after a refusal clears reject
        run_op(2'd1, 7'h02, 16'h0000, 32'h0, 32'hC000_0020, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule